// File: doc/BRIEF.md
# Programmable Binary-Weighted Delay Line

This block delays a single-bit signal by a programmable number of clock cycles. The signal first passes through a fixed delay of `MIN_DLY` cycles. It then runs through a chain of stages with weights 2^(NBITS-1) down to 1, followed by one trailing unit stage. Each stage either inserts its shift register into the path or bypasses it, so a select code `code` adds exactly `code` cycles to the fixed delay. Every stage register shifts on every clock, whether or not it is in the path. A new setting therefore needs no flush; once the delayed data has reached the end of the new path, the output is correct.

The select code and a cascade bit pass through a load/hold control latch. While `hold` is low the inputs act directly. While `hold` is high the last value sampled with `hold` low stays in force. Two override inputs select the shortest or the longest path, and the shortest path takes priority. An output-disable input forces the output low. The latched cascade bit is driven out as a complementary pair, so a second delay line further down the chain can be steered.

Top module: `prog_delay_line`

## Requirements
- R1: With no override active, the delay from `sig_in` to `sig_out` is `MIN_DLY + code` clock cycles. Bit 0 of `code` weighs 1 cycle and bit NBITS-1 weighs 2^(NBITS-1) cycles.
- R2: A code of zero still gives a delay of `MIN_DLY` cycles.
- R3: While `hold` is low, `code` and `cas_sel` take effect directly. While `hold` is high, the values sampled at the last rising clock edge with `hold` low stay in force, and later changes on `code` and `cas_sel` have no effect on the delay or on the cascade outputs.
- R4: While `force_min` is high, the delay is `MIN_DLY` cycles, whatever the values of `force_max` and `code`.
- R5: While `force_max` is high and `force_min` is low, the delay is `MIN_DLY + 2^NBITS` cycles, which is one cycle more than the all-ones code.
- R6: While `out_dis` is high, `sig_out` is low. While it is low, the delayed signal appears on `sig_out`.
- R7: `cas_out` equals the effective cascade bit (live or held, according to R3), and `cas_out_n` is always its complement.
- R8: A clock edge with `rst_n` low clears every stage register and the held control value. After reset, with `hold` high, the effective code is zero and `cas_out` is low.
- R9: After any change of code, override or hold state, `sig_out` follows the new delay from `MIN_DLY + 2^NBITS` cycles after the change onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay unit is one period |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Signal to be delayed |
| code | input | NBITS | Delay select code, bit 0 least significant |
| cas_sel | input | 1 | Cascade control bit, latched with the code |
| hold | input | 1 | Low: control latch transparent; high: control latch holds |
| force_min | input | 1 | Selects the shortest delay; has top priority |
| force_max | input | 1 | Selects the longest delay |
| out_dis | input | 1 | High forces `sig_out` low |
| sig_out | output | 1 | Delayed signal |
| cas_out | output | 1 | Effective cascade bit |
| cas_out_n | output | 1 | Complement of `cas_out` |

## Verification
The min-path assertion assumes that `sig_in` is a clean clock-synchronous bit stream. It compares `sig_out` against a reference shifted by `MIN_DLY`, which is valid only because the fixed stage always sits in the path. The hold assertion assumes that the effective control value is sampled only at rising edges. For that reason the bench changes `hold`, `code` and every override only at falling edges. In the hold test it also raises `hold` and changes `code` at the same falling edge, so that the capture rule is exercised. All data checks wait the longest delay after each control change before they sample, which keeps them inside the settling window of R9.

// File: rtl/pdl_pkg.sv
// Shared types for the programmable delay line.
// Assumes nothing beyond a single clock domain.
package pdl_pkg;

    typedef enum logic [1:0] {
        PATH_CODE = 2'd0,
        PATH_MIN  = 2'd1,
        PATH_MAX  = 2'd2
    } path_mode_e;

    // Priority decode: the shortest path wins over the longest, both win over the code.
    function automatic path_mode_e pick_mode(input logic fmin, input logic fmax);
        if (fmin)      return PATH_MIN;
        else if (fmax) return PATH_MAX;
        else           return PATH_CODE;
    endfunction

endpackage

// File: rtl/pdl_shift.sv
// Plain shift register of LEN flops delaying din by LEN cycles.
// Assumes LEN >= 1; synchronous active-low reset clears all flops.
module pdl_shift #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] sr;

    // Shift one position per clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= din;
            for (int i = 1; i < LEN; i++) sr[i] <= sr[i-1];
        end
    end

    assign dout = sr[LEN-1];
endmodule

// File: rtl/pdl_stage.sv
// One weighted stage: a WEIGHT-cycle shift register plus a bypass mux.
// The register always shifts, so switching the mux needs no flush.
module pdl_stage #(
    parameter int WEIGHT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic insert,
    output logic dout
);
    logic delayed;

    pdl_shift #(.LEN(WEIGHT)) u_sr (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (delayed)
    );

    // Choose between the delayed and the bypassed signal.
    always_comb dout = insert ? delayed : din;
endmodule

// File: rtl/pdl_ctrl.sv
// Control latch and override decode.
// Holds {cas_sel, code} while hold is high; the value captured is the one
// sampled at the last rising edge with hold low. Overrides are not latched.
module pdl_ctrl
    import pdl_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] code,
    input  logic             cas_sel,
    input  logic             hold,
    input  logic             force_min,
    input  logic             force_max,
    output logic [NBITS-1:0] ins,
    output logic             ins_tail,
    output logic             cas
);
    logic [NBITS:0] held;
    logic [NBITS:0] live;
    path_mode_e     mode;

    // Track the inputs while the latch is open; freeze them while it holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     held <= '0;
        else if (!hold) held <= {cas_sel, code};
    end

    // Effective control word: live inputs when open, held copy when closed.
    always_comb live = hold ? held : {cas_sel, code};

    // Turn the mode and code into per-stage insert enables.
    always_comb begin
        mode = pick_mode(force_min, force_max);
        unique case (mode)
            PATH_MIN: begin
                ins      = '0;
                ins_tail = 1'b0;
            end
            PATH_MAX: begin
                ins      = '1;
                ins_tail = 1'b1;
            end
            default: begin
                ins      = live[NBITS-1:0];
                ins_tail = 1'b0;
            end
        endcase
    end

    // The cascade bit always follows the effective word, whatever override is active.
    always_comb cas = live[NBITS];
endmodule

// File: rtl/prog_delay_line.sv
// Programmable delay line: fixed MIN_DLY-cycle section, binary-weighted
// stages from MSB to LSB, then one unit stage used only by the max override.
// Assumes sig_in is synchronous to clk; sig_out is gated low by out_dis.
module prog_delay_line #(
    parameter int NBITS   = 10,
    parameter int MIN_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [NBITS-1:0] code,
    input  logic             cas_sel,
    input  logic             hold,
    input  logic             force_min,
    input  logic             force_max,
    input  logic             out_dis,
    output logic             sig_out,
    output logic             cas_out,
    output logic             cas_out_n
);
    logic [NBITS-1:0] ins;
    logic             ins_tail;
    logic             cas;
    logic [NBITS:0]   node;
    logic             tail_out;

    pdl_ctrl #(.NBITS(NBITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (code),
        .cas_sel  (cas_sel),
        .hold     (hold),
        .force_min(force_min),
        .force_max(force_max),
        .ins      (ins),
        .ins_tail (ins_tail),
        .cas      (cas)
    );

    pdl_shift #(.LEN(MIN_DLY)) u_fixed (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .dout (node[NBITS])
    );

    for (genvar k = NBITS - 1; k >= 0; k--) begin : g_stage
        pdl_stage #(.WEIGHT(1 << k)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (node[k+1]),
            .insert(ins[k]),
            .dout  (node[k])
        );
    end

    pdl_stage #(.WEIGHT(1)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (node[0]),
        .insert(ins_tail),
        .dout  (tail_out)
    );

    // Gate the delayed signal with the output disable.
    always_comb sig_out = out_dis ? 1'b0 : tail_out;

    // Drive the cascade pair from the effective cascade bit.
    always_comb begin
        cas_out   = cas;
        cas_out_n = ~cas;
    end
endmodule

// File: rtl/pdl_checker.sv
// Assertion checker for prog_delay_line, attached with bind.
// Keeps its own MIN_DLY-deep reference of sig_in for the shortest path.
module pdl_checker #(
    parameter int MIN_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sig_in,
    input logic hold,
    input logic force_min,
    input logic out_dis,
    input logic sig_out,
    input logic cas_out,
    input logic cas_out_n
);
    logic [MIN_DLY-1:0] ref_sr;
    logic               started;

    // Reference delay of sig_in by MIN_DLY cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sr <= '0;
        end else begin
            ref_sr[0] <= sig_in;
            for (int i = 1; i < MIN_DLY; i++) ref_sr[i] <= ref_sr[i-1];
        end
    end

    // Mark that one full cycle out of reset has passed, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R6
    out_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> !sig_out);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started && hold && $past(hold) |-> $stable(cas_out));

    // R7
    cas_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_out != cas_out_n);

    // R4
    min_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_min && !out_dis |-> sig_out == ref_sr[MIN_DLY-1]);
endmodule

bind prog_delay_line pdl_checker #(.MIN_DLY(MIN_DLY)) u_pdl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (sig_in),
    .hold     (hold),
    .force_min(force_min),
    .out_dis  (out_dis),
    .sig_out  (sig_out),
    .cas_out  (cas_out),
    .cas_out_n(cas_out_n)
);

// File: tb/tb_prog_delay_line.sv
`timescale 1ns/1ps
module tb_prog_delay_line;
    localparam int NB   = 4;
    localparam int MIND = 2;
    localparam int MAXD = MIND + (1 << NB);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sig_in = 1'b0;
    logic [NB-1:0] code;
    logic          cas_sel, hold, force_min, force_max, out_dis;
    logic          sig_out, cas_out, cas_out_n;

    int       errors = 0;
    int       checks = 0;
    int       cyc = 0;
    bit       hist [64];
    bit       done = 1'b0;
    bit [15:0] lfsr = 16'hACE1;

    prog_delay_line #(.NBITS(NB), .MIN_DLY(MIND)) dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .code(code),
        .cas_sel(cas_sel), .hold(hold), .force_min(force_min),
        .force_max(force_max), .out_dis(out_dis), .sig_out(sig_out),
        .cas_out(cas_out), .cas_out_n(cas_out_n)
    );

    always #2.5 clk = ~clk;

    // Stimulus stream: a new pseudo-random bit each cycle, recorded by cycle index.
    always @(posedge clk) begin
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sig_in <= lfsr[0];
        hist[(cyc + 1) & 63] <= lfsr[0];
        cyc    <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Let the path settle, then compare sig_out with the input from d cycles earlier.
    task automatic check_delay(input string req, input int d, input int n);
        repeat (MAXD + 1) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, int'(sig_out), int'(hist[(cyc - d) & 63]));
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hold = 1'b1; code = 4'd7; cas_sel = 1'b1;
        force_min = 1'b0; force_max = 1'b0; out_dis = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset clears the held word and the stage registers
        chk("R8 out in reset", int'(sig_out), 0);
        chk("R8 cas_out in reset", int'(cas_out), 0);
        chk("R7 cas_out_n in reset", int'(cas_out_n), 1);
        rst_n = 1'b1;
        // R8: after reset with hold high, the effective code is zero (R2 delay)
        check_delay("R8 R2 zero code after reset", MIND, 4);
        chk("R8 cas_out after reset", int'(cas_out), 0);

        // R1 R2 R7 R9: exhaustive sweep of code and cascade bit, latch open
        hold = 1'b0;
        for (int cs = 0; cs < 2; cs++) begin
            for (int c = 0; c < (1 << NB); c++) begin
                @(negedge clk);
                code = c[NB-1:0]; cas_sel = cs[0];
                check_delay((c == 0) ? "R2 zero code" : "R1 R9 code delay", MIND + c, 3);
                chk("R7 cas_out", int'(cas_out), cs);
                chk("R7 cas_out_n", int'(cas_out_n), 1 - cs);
            end
        end

        // R4: the shortest path overrides the code and the other override
        @(negedge clk); code = '1; force_min = 1'b1;
        check_delay("R4 min over code", MIND, 4);
        @(negedge clk); force_max = 1'b1;
        check_delay("R4 min over max", MIND, 4);
        // R5: the longest path is one more than all-ones
        @(negedge clk); force_min = 1'b0;
        check_delay("R5 max delay", MAXD, 4);
        @(negedge clk); code = 4'd3;
        check_delay("R5 max over code", MAXD, 4);
        @(negedge clk); force_max = 1'b0;

        // R3: capture on the hold rise; simultaneous and later changes are ignored
        @(negedge clk); code = 4'd5; cas_sel = 1'b1;
        check_delay("R3 open latch", MIND + 5, 3);
        @(negedge clk); hold = 1'b1; code = 4'd9; cas_sel = 1'b0;
        check_delay("R3 held code", MIND + 5, 4);
        chk("R3 held cascade", int'(cas_out), 1);
        @(negedge clk); code = 4'd12;
        check_delay("R3 change while held", MIND + 5, 3);
        @(negedge clk); hold = 1'b0;
        check_delay("R3 R9 reopened latch", MIND + 12, 4);
        chk("R3 reopened cascade", int'(cas_out), 0);

        // R6: disable forces low, release restores the delayed signal
        @(negedge clk); out_dis = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R6 disabled low", int'(sig_out), 0);
        end
        @(negedge clk); out_dis = 1'b0;
        check_delay("R6 enabled", MIND + 12, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule